// File: doc/BRIEF.md
# Width-Configurable Packet Link Serializer

This block carries a stream of 32-bit packet words, each tagged as command or data, over a narrow link and rebuilds them at the far end. The transmit half spreads each word over as many bit-times as the configured lane count needs. It drives a control line beside the lanes that marks command content. When it has nothing to send, it fills the link with no-operation command words. Each of these reports how many receive buffer entries are free locally.

The receive half counts bit-times and reassembles the words, recovering each tag from the control line. It strips out the no-operation words and records the free-entry count they carry. It flags a control line that changes partway through a word, and a run of data words too long to be one packet.

The lane count is picked by a code that is sampled once, when reset is released. In use, the transmit lanes of one instance feed the receive lanes of the peer. The bench wires an instance back to itself.

Top module: `pkt_link_serdes`

## Requirements
- R1: `width_code` is captured on the first clock edge after `rst_n` rises and held until the next reset. Codes 0, 1, 2, 3 and 4 select 2, 4, 8, 16 and 32 lanes; codes 5 to 7 select 8 lanes. Under continuous input, one word is accepted every 32/lanes cycles.
- R2: In bit-time k of a word (k = 0 first), lanes 0..L-1 of `tx_lanes` carry word bits [k*L +: L], where L is the lane count. Lanes L and above are 0.
- R3: `tx_ctl` holds the same value for every bit-time of a word: 1 for a command word and 0 for a data word.
- R4: `in_ready` is high only in a cycle that loads a new word into the transmitter, which is once per word. It is never high before the width has been captured. A word in progress is always finished before the next one starts.
- R5: In a load cycle with `in_valid` low, the transmitter sends a no-operation command word. Its bits [5:0] are 0, its bits [11:8] hold `buf_free`, and all other bits are 0. Command words with bits [5:0] equal to 0 are reserved for this use.
- R6: The receiver delivers each received word with its tag on `out_word`/`out_cmd`, in the order sent. With `out_ready` high, `out_valid` first shows the word 32/lanes cycles after the clock edge that accepted it at `in_valid`/`in_ready`.
- R7: Received no-operation words are not delivered. `peer_free` takes bits [11:8] of the most recent one.
- R8: If a bit-time other than the first carries a control value different from that of the first bit-time of the same word, `frame_err` is high in the next cycle and the word is dropped.
- R9: Data words are counted since the last command word (including no-operation words). `len_err` pulses for one cycle, together with delivery of the ninth such word. Runs of 1 to 8 data words raise no error.
- R10: While `out_ready` is low, `out_valid` and `out_word` hold.
- R11: During reset, `in_ready`, `tx_active`, `out_valid`, `frame_err` and `len_err` are 0, and `peer_free` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit-time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_code | input | 3 | Lane count selection, sampled at reset release |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Transmitter loads a word this cycle |
| in_word | input | 32 | Input word |
| in_cmd | input | 1 | Input word is a command (1) or data (0) |
| buf_free | input | 4 | Local free receive entries, sent in no-operation words |
| tx_lanes | output | 32 | Transmit lanes |
| tx_ctl | output | 1 | Transmit control line |
| tx_active | output | 1 | Transmit link is running |
| rx_lanes | input | 32 | Receive lanes |
| rx_ctl | input | 1 | Receive control line |
| rx_active | input | 1 | Receive link is running |
| out_valid | output | 1 | Rebuilt word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Rebuilt word |
| out_cmd | output | 1 | Rebuilt word's command tag |
| peer_free | output | 4 | Free entries reported by the peer |
| frame_err | output | 1 | Control line changed inside a word |
| len_err | output | 1 | Data run exceeded eight words |

## Verification
A word taken at the accepting edge shows its first bit-time in the following cycle. The received word appears on `out_valid` exactly 32/lanes cycles after that edge, and `frame_err` and `len_err` rise in the cycle after the bit-time that caused them. The bench records the cycle count at every accept and every delivery, and compares the differences against the lane count. It reads lane values, flags and held outputs at falling edges, a known number of edges after the accept, so each sample falls inside the cycle in which the result is due.

// File: rtl/pkt_link_pkg.sv
package pkt_link_pkg;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned LOG_W          = 3;
  localparam int unsigned CODE_W         = 3;
  localparam int unsigned FREE_W         = 4;
  localparam int unsigned OPC_W          = 6;
  localparam int unsigned FREE_LSB       = 8;
  localparam int unsigned MAX_DATA_WORDS = 8;
  localparam logic [LOG_W-1:0] LOG_DEFAULT = 3'd3;

  // log2 of the lane count chosen by a width code
  function automatic logic [LOG_W-1:0] lane_log_of(input logic [CODE_W-1:0] code);
    logic [LOG_W-1:0] r;
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: r = code + 3'd1;
      default:                      r = LOG_DEFAULT;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/plk_width_ctl.sv
module plk_width_ctl
  import pkt_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] width_code,
  output logic [LOG_W-1:0]  lane_log,
  output logic              cfg_done
);
  logic [LOG_W-1:0] log_q, log_d;
  logic             done_q;

  always_comb log_d = lane_log_of(width_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_q  <= LOG_DEFAULT;
      done_q <= 1'b0;
    end else if (!done_q) begin
      log_q  <= log_d;
      done_q <= 1'b1;
    end
  end

  assign lane_log = log_q;
  assign cfg_done = done_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable(log_q)); // R1
  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (log_q >= 3'd1 && log_q <= 3'd5)); // R1
endmodule

// File: rtl/plk_tx.sv
module plk_tx
  import pkt_link_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned FW = FREE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_done,
  input  logic [LOG_W-1:0] lane_log,
  input  logic             in_valid,
  input  logic [W-1:0]     in_word,
  input  logic             in_cmd,
  input  logic [FW-1:0]    buf_free,
  output logic             in_ready,
  output logic [W-1:0]     link_data,
  output logic             link_ctl,
  output logic             link_valid
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W:0] W_CNT = (CNT_W+1)'(W);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_idx, shamt;
  logic [CNT_W:0]   nbt, lanes;
  logic [W-1:0]     word_q, word_d, mask, nop_w;
  logic             cmd_q, cmd_d, act_q, act_d, load, adv;

  always_comb begin
    nbt      = W_CNT >> lane_log;
    last_idx = nbt[CNT_W-1:0] - CNT_W'(1);
    lanes    = (CNT_W+1)'(1) << lane_log;
    mask     = ~({W{1'b1}} << lanes);
    shamt    = cnt_q << lane_log;
    nop_w    = '0;
    nop_w[FREE_LSB +: FW] = buf_free;
  end

  // next state
  always_comb begin
    load   = cfg_done && (!act_q || cnt_q == last_idx);
    adv    = load || act_q;
    cnt_d  = cnt_q + CNT_W'(1);
    word_d = word_q;
    cmd_d  = cmd_q;
    act_d  = act_q;
    if (load) begin
      cnt_d  = '0;
      act_d  = 1'b1;
      word_d = in_valid ? in_word : nop_w;
      cmd_d  = in_valid ? in_cmd  : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      cmd_q  <= 1'b0;
      act_q  <= 1'b0;
    end else if (adv) begin
      cnt_q  <= cnt_d;
      word_q <= word_d;
      cmd_q  <= cmd_d;
      act_q  <= act_d;
    end
  end

  assign in_ready   = load;
  assign link_valid = act_q;
  assign link_ctl   = act_q & cmd_q;
  assign link_data  = act_q ? ((word_q >> shamt) & mask) : '0;

  AST_CTL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0) |-> (link_ctl == $past(link_ctl))); // R3
  AST_READY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && lane_log != 3'd5) |=> !in_ready); // R4
  AST_READY_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !in_ready); // R4
  AST_BT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q <= last_idx)); // R1
endmodule

// File: rtl/plk_rx.sv
module plk_rx
  import pkt_link_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned FW   = FREE_W,
  parameter int unsigned MAXW = MAX_DATA_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOG_W-1:0] lane_log,
  input  logic [W-1:0]     link_data,
  input  logic             link_ctl,
  input  logic             link_valid,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_word,
  output logic             out_cmd,
  output logic [FW-1:0]    peer_free,
  output logic             frame_err,
  output logic             len_err
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam int unsigned RUN_W = $clog2(MAXW + 2);
  localparam logic [CNT_W:0] W_CNT = (CNT_W+1)'(W);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_idx, shamt;
  logic [CNT_W:0]   nbt, lanes;
  logic [W-1:0]     mask, piece, acc_q, acc_d, ow_q, ow_d;
  logic             ctl0_q, bad_q, bad_d, first, mismatch, word_done, word_ok;
  logic             word_cmd, is_nop, deliver;
  logic             ov_q, ov_d, oc_q, oc_d, frm_q, len_q, len_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [FW-1:0]    free_q, free_d;

  always_comb begin
    nbt      = W_CNT >> lane_log;
    last_idx = nbt[CNT_W-1:0] - CNT_W'(1);
    lanes    = (CNT_W+1)'(1) << lane_log;
    mask     = ~({W{1'b1}} << lanes);
    shamt    = cnt_q << lane_log;
    piece    = (link_data & mask) << shamt;
  end

  // next state
  always_comb begin
    first     = (cnt_q == '0);
    acc_d     = first ? piece : (acc_q | piece);
    mismatch  = link_valid && !first && (link_ctl != ctl0_q);
    bad_d     = (first ? 1'b0 : bad_q) | mismatch;
    word_done = link_valid && (cnt_q == last_idx);
    word_ok   = word_done && !bad_d;
    word_cmd  = first ? link_ctl : ctl0_q;
    is_nop    = word_cmd && (acc_d[OPC_W-1:0] == '0);
    deliver   = word_ok && !is_nop;
    cnt_d     = word_done ? '0 : cnt_q + CNT_W'(1);

    ov_d = ov_q && !out_ready;
    ow_d = ow_q;
    oc_d = oc_q;
    if (deliver) begin
      ov_d = 1'b1;
      ow_d = acc_d;
      oc_d = word_cmd;
    end

    run_d = run_q;
    len_d = 1'b0;
    if (word_ok) begin
      if (word_cmd) begin
        run_d = '0;
      end else if (run_q <= RUN_W'(MAXW)) begin
        run_d = run_q + RUN_W'(1);
        len_d = (run_q == RUN_W'(MAXW));
      end
    end

    free_d = (word_ok && is_nop) ? acc_d[FREE_LSB +: FW] : free_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      ctl0_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (link_valid) begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      bad_q  <= bad_d;
      if (first) ctl0_q <= link_ctl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      ow_q   <= '0;
      oc_q   <= 1'b0;
      frm_q  <= 1'b0;
      len_q  <= 1'b0;
      run_q  <= '0;
      free_q <= '0;
    end else begin
      ov_q   <= ov_d;
      ow_q   <= ow_d;
      oc_q   <= oc_d;
      frm_q  <= mismatch;
      len_q  <= len_d;
      run_q  <= run_d;
      free_q <= free_d;
    end
  end

  assign out_valid = ov_q;
  assign out_word  = ow_q;
  assign out_cmd   = oc_q;
  assign frame_err = frm_q;
  assign len_err   = len_q;
  assign peer_free = free_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> ov_q); // R10
  AST_FRM_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q |-> ($past(link_valid) && $past(cnt_q) != '0)); // R8
  AST_LEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    len_q |=> !len_q); // R9
  AST_NOP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> !(oc_q && ow_q[OPC_W-1:0] == '0)); // R7
endmodule

// File: rtl/pkt_link_serdes.sv
module pkt_link_serdes
  import pkt_link_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  width_code,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               in_cmd,
  input  logic [FREE_W-1:0]  buf_free,
  output logic [WORD_W-1:0]  tx_lanes,
  output logic               tx_ctl,
  output logic               tx_active,
  input  logic [WORD_W-1:0]  rx_lanes,
  input  logic               rx_ctl,
  input  logic               rx_active,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_word,
  output logic               out_cmd,
  output logic [FREE_W-1:0]  peer_free,
  output logic               frame_err,
  output logic               len_err
);
  logic [LOG_W-1:0] lane_log;
  logic             cfg_done;

  plk_width_ctl u_cfg (
    .clk(clk), .rst_n(rst_n), .width_code(width_code),
    .lane_log(lane_log), .cfg_done(cfg_done)
  );

  plk_tx #(.W(WORD_W), .FW(FREE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .lane_log(lane_log),
    .in_valid(in_valid), .in_word(in_word), .in_cmd(in_cmd), .buf_free(buf_free),
    .in_ready(in_ready), .link_data(tx_lanes), .link_ctl(tx_ctl), .link_valid(tx_active)
  );

  plk_rx #(.W(WORD_W), .FW(FREE_W), .MAXW(MAX_DATA_WORDS)) u_rx (
    .clk(clk), .rst_n(rst_n), .lane_log(lane_log),
    .link_data(rx_lanes), .link_ctl(rx_ctl), .link_valid(rx_active),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word), .out_cmd(out_cmd),
    .peer_free(peer_free), .frame_err(frame_err), .len_err(len_err)
  );
endmodule

// File: tb/sim_pkt_link_serdes.sv
`timescale 1ns/1ps
module sim_pkt_link_serdes;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  width_code;
  logic        in_valid, in_ready, in_cmd;
  logic [31:0] in_word;
  logic [3:0]  buf_free;
  logic [31:0] tx_lanes;
  logic        tx_ctl, tx_active;
  logic        inject;
  logic        out_valid, out_ready, out_cmd;
  logic [31:0] out_word;
  logic [3:0]  peer_free;
  logic        frame_err, len_err;

  int checks = 0, failures = 0, cyc = 0;
  int rx_n = 0, len_cnt = 0;
  logic clr = 1'b1;
  logic done = 1'b0;
  logic [31:0] lg_w [0:31];
  logic        lg_c [0:31];
  int          lg_t [0:31];

  always #2 clk = ~clk;

  pkt_link_serdes u0 (
    .clk(clk), .rst_n(rst_n), .width_code(width_code),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_cmd(in_cmd),
    .buf_free(buf_free), .tx_lanes(tx_lanes), .tx_ctl(tx_ctl), .tx_active(tx_active),
    .rx_lanes(tx_lanes), .rx_ctl(tx_ctl ^ inject), .rx_active(tx_active),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_cmd(out_cmd),
    .peer_free(peer_free), .frame_err(frame_err), .len_err(len_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (clr) begin
      rx_n    = 0;
      len_cnt = 0;
    end else begin
      if (out_valid && out_ready && rx_n < 32) begin
        lg_w[rx_n] = out_word;
        lg_c[rx_n] = out_cmd;
        lg_t[rx_n] = cyc;
        rx_n = rx_n + 1;
      end
      if (len_err) len_cnt = len_cnt + 1;
    end
  end

  typedef struct packed {
    logic [2:0]  code;
    logic [5:0]  nbt;
    logic [31:0] w;
    logic        c;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 6'd16, 32'hA5C3_0F81, 1'b1},
    '{3'd0, 6'd16, 32'h0000_0001, 1'b0},
    '{3'd1, 6'd8,  32'h1357_9BDF, 1'b1},
    '{3'd1, 6'd8,  32'hFFFF_0000, 1'b0},
    '{3'd2, 6'd4,  32'h8000_0042, 1'b1},
    '{3'd2, 6'd4,  32'h7E7E_1818, 1'b0},
    '{3'd3, 6'd2,  32'hDEAD_BEEF, 1'b1},
    '{3'd3, 6'd2,  32'h0F0F_F0F0, 1'b0},
    '{3'd4, 6'd1,  32'hCAFE_F00D, 1'b1},
    '{3'd4, 6'd1,  32'h1234_5678, 1'b0},
    '{3'd6, 6'd4,  32'h2468_ACE1, 1'b1},
    '{3'd7, 6'd4,  32'h5555_AAAA, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] code);
    rst_n = 1'b0; width_code = code; in_valid = 1'b0; in_word = '0; in_cmd = 1'b0;
    inject = 1'b0; clr = 1'b1;
    repeat (3) @(negedge clk);
    clr = 1'b0; rst_n = 1'b1;
  endtask

  task automatic send(input logic [31:0] w, input logic c, output int t);
    in_word = w; in_cmd = c; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    t = cyc + 1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int t0, t1, t2, cnt;
    logic [31:0] w1, w2;
    out_ready = 1'b1; buf_free = 4'h3;
    do_reset(3'd2);
    rst_n = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!in_ready && !tx_active, "R11 tx idle in reset", {30'd0, in_ready, tx_active}, 32'd0);
    chk(!out_valid && !frame_err && !len_err && peer_free == 4'h0, "R11 rx idle in reset",
        {25'd0, out_valid, frame_err, len_err, peer_free}, 32'd0);
    // R4 no ready before capture
    @(negedge clk);
    rst_n = 1'b1;
    chk(!in_ready, "R4 no ready before width capture", {31'd0, in_ready}, 32'd0);

    // vector table: loopback at every width
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i].code);
      repeat (6) @(negedge clk);
      chk(rx_n == 0, "R7 idle fill not delivered", rx_n, 0);
      w1 = ~VEC[i].w;
      w2 = VEC[i].w ^ 32'h5A5A_C3C3;
      send(VEC[i].w, VEC[i].c, t0);
      send(w1, 1'b0, t1);
      send(w2, 1'b0, t2);
      chk(t1 - t0 == int'(VEC[i].nbt), "R1 bit-times per word", t1 - t0, VEC[i].nbt);
      chk(t2 - t1 == int'(VEC[i].nbt), "R4 one load per word", t2 - t1, VEC[i].nbt);
      repeat (int'(VEC[i].nbt) + 4) @(negedge clk);
      chk(rx_n == 3, "R6 word count", rx_n, 3);
      chk(lg_w[0] == VEC[i].w && lg_c[0] == VEC[i].c, "R6 R3 first word and tag", lg_w[0], VEC[i].w);
      chk(lg_w[1] == w1 && !lg_c[1], "R6 R3 second word data", lg_w[1], w1);
      chk(lg_w[2] == w2 && !lg_c[2], "R6 third word in order", lg_w[2], w2);
      chk(lg_t[0] - t0 == int'(VEC[i].nbt), "R6 delivery latency", lg_t[0] - t0, VEC[i].nbt);
    end

    // R2 lane order at 8 lanes
    do_reset(3'd2);
    repeat (3) @(negedge clk);
    send(32'h4433_2211, 1'b0, t0);
    chk(tx_lanes == 32'h11 && !tx_ctl, "R2 bit-time 0 lanes", tx_lanes, 32'h11);
    @(negedge clk);
    chk(tx_lanes == 32'h22 && !tx_ctl, "R2 R3 bit-time 1 lanes", tx_lanes, 32'h22);
    @(negedge clk);
    chk(tx_lanes == 32'h33, "R2 bit-time 2 lanes", tx_lanes, 32'h33);

    // R4 ready pulses at 4 lanes while idle
    do_reset(3'd1);
    repeat (4) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 16; k++) begin
      if (in_ready) cnt++;
      @(negedge clk);
    end
    chk(cnt == 2, "R4 ready once per 8 bit-times", cnt, 2);

    // R5 R7 no-operation content and free count
    do_reset(3'd4);
    buf_free = 4'hA;
    repeat (4) @(negedge clk);
    chk(tx_lanes == 32'h0000_0A00 && tx_ctl, "R5 no-operation word", tx_lanes, 32'h0000_0A00);
    chk(peer_free == 4'hA, "R7 peer free count", peer_free, 4'hA);
    chk(rx_n == 0, "R7 no-operation dropped", rx_n, 0);

    // R8 framing error at 2 lanes
    do_reset(3'd0);
    repeat (3) @(negedge clk);
    send(32'h1234_5678, 1'b0, t0);
    @(negedge clk);
    @(negedge clk);
    inject = 1'b1;
    @(negedge clk);
    inject = 1'b0;
    chk(frame_err, "R8 frame error flagged", {31'd0, frame_err}, 32'd1);
    @(negedge clk);
    chk(!frame_err, "R8 frame error single pulse", {31'd0, frame_err}, 32'd0);
    repeat (20) @(negedge clk);
    chk(rx_n == 0, "R8 errored word dropped", rx_n, 0);
    send(32'h0BAD_F00D, 1'b0, t0);
    repeat (20) @(negedge clk);
    chk(rx_n == 1 && lg_w[0] == 32'h0BAD_F00D, "R8 recovery next word", lg_w[0], 32'h0BAD_F00D);

    // R9 data run length at 32 lanes
    do_reset(3'd4);
    repeat (3) @(negedge clk);
    send(32'h0000_0041, 1'b1, t0);
    for (int k = 0; k < 8; k++) send(32'h100 + k, 1'b0, t0);
    repeat (4) @(negedge clk);
    chk(len_cnt == 0, "R9 eight data words accepted", len_cnt, 0);
    send(32'h0000_0042, 1'b1, t0);
    for (int k = 0; k < 9; k++) send(32'h200 + k, 1'b0, t0);
    repeat (4) @(negedge clk);
    chk(len_cnt == 1, "R9 ninth data word flagged", len_cnt, 1);
    chk(rx_n == 19, "R9 words still delivered", rx_n, 19);

    // R10 hold while not ready
    do_reset(3'd2);
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    send(32'h7777_1234, 1'b0, t0);
    repeat (10) @(negedge clk);
    chk(out_valid && out_word == 32'h7777_1234, "R10 output held", out_word, 32'h7777_1234);
    chk(rx_n == 0, "R10 nothing taken", rx_n, 0);
    @(posedge clk);
    #1 out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rx_n == 1 && !out_valid, "R10 taken once", rx_n, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule